// File: doc/BRIEF.md
# Disk Transfer Sequencer

This block runs the data-moving part of a disk controller's read and write commands. When the command unit issues a transfer it supplies the disk address, the word count as a negative two's-complement number, a 16-bit bus address and two upper address bits. The sequencer works out the byte count, the starting memory address and the starting cylinder, head and sector. It then moves the data one sector-sized chunk at a time.

For a write, the bytes of each chunk are fetched from memory into an internal sector buffer, and the whole buffer is handed to the storage port. For a read, the storage port fills the buffer, and its bytes are then written to memory. Memory is reached one byte at a time through a request/ready handshake. Each storage access carries a linear media offset that is computed from the current geometry, and the geometry advances after every chunk. A storage error ends the command at once. Every accepted command ends with a one-cycle completion pulse.

Top module: `dma_xfer_seq`

## Requirements
- R1: A command is accepted only in idle with `cmd_valid` high and `cmd_code` equal to 5 (write), 6 or 7 (read; both behave alike). Any other code leaves `busy`, `done`, `mem_req` and `sto_start` low.
- R2: The transfer length in bytes is (65536 − `word_cnt`) × 2. A result of exactly 65536 is taken as zero: the command completes with no memory or storage activity.
- R3: The first memory byte address is {`addr_hi`, `bus_addr`[15:1], 0}. Each completed byte handshake advances it by one, wrapping modulo 2^18.
- R4: The starting sector is `disk_addr`[5:0], the head is `disk_addr`[6] and the cylinder is `disk_addr`[15:7]. At each `sto_start`, `sto_ofs` equals ((cylinder × 2 + head) × SPT + sector) × BPS, taken modulo 2^OFS_W.
- R5: The length of each chunk, shown on `sto_len`, is the smaller of the bytes remaining and BPS, so the last chunk may be short.
- R6: After each chunk the sector increments. When it reaches SPT it returns to 0 and the head increments. When the head passes 1 it returns to 0 and the cylinder increments.
- R7: On a write, the chunk's bytes are read from memory in address order before `sto_start`, which comes with `sto_write` = 1. Byte i of the chunk sits at bits 8i+7:8i of `sto_wdata`.
- R8: On a read, `sto_start` comes with `sto_write` = 0. `sto_rdata` is captured on `sto_done`, and its first `sto_len` bytes (byte i at bits 8i+7:8i) are then written to memory in address order.
- R9: If `sto_err` is high with `sto_done`, no further memory or storage activity follows and `done` pulses on the next cycle. On a read, the failed chunk writes nothing to memory.
- R10: `busy` is high from the cycle after a command is accepted until the cycle in which `done` pulses, inclusive. `done` lasts exactly one cycle.
- R11: While `mem_req` is high and `mem_rdy` is low, the request stays up next cycle with `mem_addr` and `mem_we` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe from the command unit |
| cmd_code | input | 3 | Function code (5 write, 6/7 read) |
| disk_addr | input | 16 | Cylinder/head/sector start address |
| word_cnt | input | 16 | Negative word count |
| bus_addr | input | 16 | Low memory address bits |
| addr_hi | input | 2 | Memory address bits 17:16 |
| mem_req | output | 1 | Byte memory request |
| mem_we | output | 1 | 1 = write memory, 0 = read memory |
| mem_addr | output | 18 | Byte memory address |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte read from memory, valid with mem_rdy |
| mem_rdy | input | 1 | Memory completes the byte this cycle |
| sto_start | output | 1 | One-cycle storage access start |
| sto_write | output | 1 | 1 = store buffer to media, 0 = load from media |
| sto_ofs | output | OFS_W | Linear media byte offset |
| sto_len | output | LEN_W | Chunk length in bytes |
| sto_wdata | output | BPS×8 | Sector buffer contents toward media |
| sto_rdata | input | BPS×8 | Sector data from media, valid with sto_done |
| sto_done | input | 1 | Storage access finished |
| sto_err | input | 1 | Storage access failed, valid with sto_done |
| busy | output | 1 | Drive activity, high for the whole transfer |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the sequencer with four sectors per track, 16-byte sectors and eight cylinders. With these values a transfer of a few dozen bytes already crosses sector, head and cylinder boundaries and ends on a short chunk, so R5 and R6 are exercised many times per run. The 10-bit offset keeps the expected-offset model small. The zero-length count, the wrap of the 18-bit memory address and storage errors on the first and a later chunk are run as directed cases. These are mixed with random reads and writes.

// File: rtl/dxs_pkg.sv
package dxs_pkg;

    localparam int MADDR_W = 18;
    localparam int CNT_W   = 18;

    typedef enum logic [2:0] {
        S_IDLE, S_CHUNK, S_MEMIN, S_STOGO, S_WAIT, S_MEMOUT, S_ADV, S_FINISH
    } seq_state_t;

    typedef struct packed {
        logic [8:0] cyl;
        logic       head;
        logic [5:0] sec;
    } geo_t;

    function automatic logic cmd_is_xfer(input logic [2:0] code);
        return (code == 3'd5) || (code == 3'd6) || (code == 3'd7);
    endfunction

    // byte count from a negative word count; 65536 collapses to zero
    function automatic logic [CNT_W-1:0] xfer_bytes(input logic [15:0] wc);
        logic [CNT_W-1:0] n;
        n = (18'h10000 - {2'b00, wc}) << 1;
        if (n == 18'h10000) n = '0;
        return n;
    endfunction

    function automatic logic [MADDR_W-1:0] mem_start(input logic [1:0] hi,
                                                     input logic [15:0] ba);
        return {hi, ba[15:1], 1'b0};
    endfunction

    function automatic logic [31:0] lin_offset(input geo_t g, input int spt,
                                               input int bps);
        logic [31:0] t;
        t = {23'b0, g.cyl} * 32'd2 + {31'b0, g.head};
        t = t * 32'(spt) + {26'b0, g.sec};
        return t * 32'(bps);
    endfunction

endpackage

// File: rtl/dxs_geom.sv
module dxs_geom
    import dxs_pkg::*;
#(
    parameter int SPT   = 40,
    parameter int BPS   = 256,
    parameter int OFS_W = 24
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [15:0]      load_da,
    input  logic             step,
    output logic [OFS_W-1:0] ofs
);
    geo_t g;

    always_ff @(posedge clk) begin
        if (rst) begin
            g <= '0;
        end else if (load) begin
            g <= load_da;
        end else if (step) begin
            if (int'(g.sec) + 1 >= SPT) begin
                g.sec <= '0;
                if (g.head) begin
                    g.head <= 1'b0;
                    g.cyl  <= g.cyl + 9'd1;
                end else begin
                    g.head <= 1'b1;
                end
            end else begin
                g.sec <= g.sec + 6'd1;
            end
        end
    end

    assign ofs = OFS_W'(lin_offset(g, SPT, BPS));

    // R6: a step always leaves the sector inside the track
    p_sec_in_track_r6: assert property (@(posedge clk) disable iff (rst)
        step |=> (int'(g.sec) < SPT));

endmodule

// File: rtl/dxs_sector_buf.sv
module dxs_sector_buf #(
    parameter int BPS   = 256,
    parameter int IDX_W = 8
)(
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             load_en,
    input  logic [BPS*8-1:0] load_vec,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [BPS*8-1:0] flat
);
    logic [7:0] cells [BPS];

    always_ff @(posedge clk) begin
        if (load_en) begin
            for (int i = 0; i < BPS; i++) cells[i] <= load_vec[i*8 +: 8];
        end else if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    assign rd_data = cells[rd_idx];

    for (genvar i = 0; i < BPS; i++) begin : g_flat
        assign flat[i*8 +: 8] = cells[i];
    end

endmodule

// File: rtl/dxs_byte_mover.sv
module dxs_byte_mover
    import dxs_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 9
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               addr_load,
    input  logic [MADDR_W-1:0] addr_init,
    input  logic               go,
    input  logic               to_mem,
    input  logic [LEN_W-1:0]   len,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    input  logic               mem_rdy,
    output logic [IDX_W-1:0]   buf_idx,
    input  logic [7:0]         buf_rdata,
    output logic               buf_we,
    output logic [7:0]         buf_wdata,
    output logic               fin
);
    logic               active;
    logic               dir_mem;
    logic [MADDR_W-1:0] addr;
    logic [IDX_W:0]     idx;
    logic [LEN_W-1:0]   left;
    logic               xfer;

    assign xfer = active && mem_rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            dir_mem <= 1'b0;
            addr    <= '0;
            idx     <= '0;
            left    <= '0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (addr_load) addr <= addr_init;
            if (go) begin
                active  <= 1'b1;
                dir_mem <= to_mem;
                idx     <= '0;
                left    <= len;
            end else if (xfer) begin
                addr <= addr + 1'b1;
                idx  <= idx + 1'b1;
                left <= left - 1'b1;
                if (left == LEN_W'(1)) begin
                    active <= 1'b0;
                    fin    <= 1'b1;
                end
            end
        end
    end

    assign mem_req   = active;
    assign mem_we    = dir_mem;
    assign mem_addr  = addr;
    assign mem_wdata = buf_rdata;
    assign buf_idx   = idx[IDX_W-1:0];
    assign buf_we    = xfer && !dir_mem;
    assign buf_wdata = mem_rdata;

    // R11: an unanswered request holds its address and direction
    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3: each completed byte moves the address forward by one
    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_rdy && !addr_load) |=> (mem_addr == $past(mem_addr) + 1'b1));

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dxs_pkg::*;
#(
    parameter int SPT   = 40,
    parameter int BPS   = 256,
    parameter int CYLS  = 512,
    localparam int OFS_W = $clog2(CYLS * 2 * SPT * BPS),
    localparam int LEN_W = $clog2(BPS + 1),
    localparam int IDX_W = $clog2(BPS)
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_code,
    input  logic [15:0]        disk_addr,
    input  logic [15:0]        word_cnt,
    input  logic [15:0]        bus_addr,
    input  logic [1:0]         addr_hi,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    input  logic               mem_rdy,
    output logic               sto_start,
    output logic               sto_write,
    output logic [OFS_W-1:0]   sto_ofs,
    output logic [LEN_W-1:0]   sto_len,
    output logic [BPS*8-1:0]   sto_wdata,
    input  logic [BPS*8-1:0]   sto_rdata,
    input  logic               sto_done,
    input  logic               sto_err,
    output logic               busy,
    output logic               done
);
    seq_state_t       st;
    logic [CNT_W-1:0] remain;
    logic [LEN_W-1:0] chunk;
    logic [LEN_W-1:0] chunk_next;
    logic             is_wr;
    logic             accept;
    logic [CNT_W-1:0] first_cnt;
    logic             buf_load;
    logic             mv_go;
    logic             mv_fin;
    logic [LEN_W-1:0] mv_len;
    logic [IDX_W-1:0] b_idx;
    logic [7:0]       b_rdata;
    logic             b_we;
    logic [7:0]       b_wdata;

    assign accept     = (st == S_IDLE) && cmd_valid && cmd_is_xfer(cmd_code);
    assign first_cnt  = xfer_bytes(word_cnt);
    assign chunk_next = (remain >= CNT_W'(BPS)) ? LEN_W'(BPS) : LEN_W'(remain);
    assign buf_load   = (st == S_WAIT) && sto_done && !sto_err && !is_wr;
    assign mv_go      = ((st == S_CHUNK) && is_wr) || buf_load;
    assign mv_len     = (st == S_CHUNK) ? chunk_next : chunk;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            remain <= '0;
            chunk  <= '0;
            is_wr  <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: if (accept) begin
                    is_wr  <= (cmd_code == 3'd5);
                    remain <= first_cnt;
                    st     <= (first_cnt == '0) ? S_FINISH : S_CHUNK;
                end
                S_CHUNK: begin
                    chunk <= chunk_next;
                    st    <= is_wr ? S_MEMIN : S_STOGO;
                end
                S_MEMIN:  if (mv_fin) st <= S_STOGO;
                S_STOGO:  st <= S_WAIT;
                S_WAIT: if (sto_done) begin
                    if (sto_err)    st <= S_FINISH;
                    else if (is_wr) st <= S_ADV;
                    else            st <= S_MEMOUT;
                end
                S_MEMOUT: if (mv_fin) st <= S_ADV;
                S_ADV: begin
                    remain <= remain - CNT_W'(chunk);
                    st     <= (remain == CNT_W'(chunk)) ? S_FINISH : S_CHUNK;
                end
                S_FINISH: st <= S_IDLE;
                default:  st <= S_IDLE;
            endcase
        end
    end

    dxs_geom #(.SPT(SPT), .BPS(BPS), .OFS_W(OFS_W)) u_geom (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .load_da (disk_addr),
        .step    (st == S_ADV),
        .ofs     (sto_ofs)
    );

    dxs_sector_buf #(.BPS(BPS), .IDX_W(IDX_W)) u_buf (
        .clk      (clk),
        .wr_en    (b_we),
        .wr_idx   (b_idx),
        .wr_data  (b_wdata),
        .load_en  (buf_load),
        .load_vec (sto_rdata),
        .rd_idx   (b_idx),
        .rd_data  (b_rdata),
        .flat     (sto_wdata)
    );

    dxs_byte_mover #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_mover (
        .clk       (clk),
        .rst       (rst),
        .addr_load (accept),
        .addr_init (mem_start(addr_hi, bus_addr)),
        .go        (mv_go),
        .to_mem    (!is_wr),
        .len       (mv_len),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rdy   (mem_rdy),
        .buf_idx   (b_idx),
        .buf_rdata (b_rdata),
        .buf_we    (b_we),
        .buf_wdata (b_wdata),
        .fin       (mv_fin)
    );

    assign sto_start = (st == S_STOGO);
    assign sto_write = is_wr;
    assign sto_len   = chunk;
    assign busy      = (st != S_IDLE);
    assign done      = (st == S_FINISH);

    // R10: completion is a single-cycle pulse inside the busy window
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R5: every storage access has a legal chunk length
    p_chunk_len_r5: assert property (@(posedge clk) disable iff (rst)
        sto_start |-> (sto_len != '0 && int'(sto_len) <= BPS));

    // R9: a failed storage access ends the command on the next cycle
    p_err_stop_r9: assert property (@(posedge clk) disable iff (rst)
        (st == S_WAIT && sto_done && sto_err) |=> (done && !mem_req));

    // R1: a non-transfer code leaves the sequencer idle
    p_ignore_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid && !cmd_is_xfer(cmd_code)) |=> !busy);

endmodule

// File: tb/dma_xfer_seq_test.sv
module dma_xfer_seq_test;
    localparam int SPT   = 4;
    localparam int BPS   = 16;
    localparam int CYLS  = 8;
    localparam int OFS_W = $clog2(CYLS * 2 * SPT * BPS);
    localparam int LEN_W = $clog2(BPS + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic               cmd_valid = 1'b0;
    logic [2:0]         cmd_code  = '0;
    logic [15:0]        disk_addr = '0, word_cnt = '0, bus_addr = '0;
    logic [1:0]         addr_hi   = '0;
    logic               mem_req, mem_we;
    logic [17:0]        mem_addr;
    logic [7:0]         mem_wdata;
    logic [7:0]         mem_rdata = '0;
    logic               mem_rdy   = 1'b0;
    logic               sto_start, sto_write;
    logic [OFS_W-1:0]   sto_ofs;
    logic [LEN_W-1:0]   sto_len;
    logic [BPS*8-1:0]   sto_wdata;
    logic [BPS*8-1:0]   sto_rdata = '0;
    logic               sto_done = 1'b0, sto_err = 1'b0;
    logic               busy, done;

    dma_xfer_seq #(.SPT(SPT), .BPS(BPS), .CYLS(CYLS)) uut (.*);

    int compared = 0, mismatched = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_pat(input logic [17:0] a);
        return 8'({14'b0, a} * 32'd7 + ({14'b0, a} >> 9) + 32'd3);
    endfunction

    function automatic logic [7:0] sto_pat(input int ofs, input int i);
        return 8'(ofs * 3 + i * 5 + 1);
    endfunction

    // logs filled by the port models
    logic [17:0]      wl_addr [1024];
    logic [7:0]       wl_dat  [1024];
    int               wn = 0, rd_cnt = 0;
    int               s_ofs [64];
    int               s_len [64];
    bit               s_wr  [64];
    logic [BPS*8-1:0] s_dat [64];
    int               sn = 0, err_chunk = -1;
    bit               s_pend = 0;
    int               s_dly = 0;
    bit               hold_v = 0, hold_we = 0;
    logic [17:0]      hold_addr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req) begin
                if (hold_v)
                    chk(mem_addr == hold_addr && mem_we == hold_we, "R11",
                        "held address", longint'(mem_addr), longint'(hold_addr));
                mem_rdy   = ($urandom % 4) != 0;
                mem_rdata = mem_pat(mem_addr);
                if (mem_rdy) begin
                    if (mem_we) begin
                        wl_addr[wn] = mem_addr;
                        wl_dat[wn]  = mem_wdata;
                        wn++;
                    end else rd_cnt++;
                end
                hold_v = !mem_rdy; hold_addr = mem_addr; hold_we = mem_we;
            end else begin
                if (hold_v) chk(0, "R11", "request dropped", 0, 1);
                mem_rdy = 1'b0; hold_v = 0;
            end
            sto_done = 1'b0; sto_err = 1'b0;
            if (s_pend) begin
                s_dly--;
                if (s_dly == 0) begin
                    s_pend   = 0;
                    sto_done = 1'b1;
                    sto_err  = (sn - 1 == err_chunk);
                    for (int i = 0; i < BPS; i++)
                        sto_rdata[i*8 +: 8] = sto_pat(s_ofs[sn-1], i);
                end
            end
            if (sto_start) begin
                s_ofs[sn] = int'(sto_ofs); s_len[sn] = int'(sto_len);
                s_wr[sn] = sto_write;      s_dat[sn] = sto_wdata;
                sn++;
                s_pend = 1; s_dly = 1 + int'($urandom % 4);
            end
        end
    end

    task automatic run_xfer(input logic [2:0] code, input logic [15:0] da,
                            input logic [15:0] wc, input logic [15:0] ba,
                            input logic [1:0] hi, input int errc);
        int nbytes, rem, k, len, sec, hd, cyl, pos, mexp, eofs;
        bit wr;
        logic [17:0] base;
        sn = 0; wn = 0; rd_cnt = 0; err_chunk = errc;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; disk_addr = da;
        word_cnt = wc; bus_addr = ba; addr_hi = hi;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R10", "busy after accept", longint'(busy), 1);
        while (!done && !finished) begin
            chk(busy == 1'b1, "R10", "busy during transfer", longint'(busy), 1);
            @(negedge clk);
        end
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R10", "done width",
            longint'({done, busy}), 0);
        // expected behaviour from the requirements
        wr     = (code == 3'd5);
        nbytes = (wc == 16'h8000) ? 0 : (65536 - int'(wc)) * 2;
        base   = {hi, ba[15:1], 1'b0};
        sec = int'(da[5:0]); hd = int'(da[6]); cyl = int'(da[15:7]);
        rem = nbytes; k = 0; pos = 0; mexp = 0;
        while (rem > 0 && (errc < 0 || k <= errc)) begin
            len  = (rem < BPS) ? rem : BPS;
            eofs = (((cyl * 2 + hd) * SPT + sec) * BPS) % (1 << OFS_W);
            if (k < sn) begin
                chk(s_ofs[k] == eofs, (k == 0) ? "R4" : "R6", "media offset",
                    s_ofs[k], eofs);
                chk(s_len[k] == len, "R5", "chunk length", s_len[k], len);
                chk(s_wr[k] == wr, wr ? "R7" : "R8", "direction",
                    longint'(s_wr[k]), longint'(wr));
                if (wr)
                    for (int j = 0; j < len; j++)
                        chk(s_dat[k][j*8 +: 8] == mem_pat(18'(int'(base) + pos + j)),
                            "R7", "stored byte", longint'(s_dat[k][j*8 +: 8]),
                            longint'(mem_pat(18'(int'(base) + pos + j))));
            end
            if (wr) mexp += len;
            else if (errc < 0 || k < errc) begin
                for (int j = 0; j < len; j++) begin
                    if (mexp + j < wn) begin
                        chk(wl_addr[mexp+j] == 18'(int'(base) + pos + j), "R3",
                            "memory address", longint'(wl_addr[mexp+j]),
                            longint'(18'(int'(base) + pos + j)));
                        chk(wl_dat[mexp+j] == sto_pat(eofs, j), "R8", "memory byte",
                            longint'(wl_dat[mexp+j]), longint'(sto_pat(eofs, j)));
                    end
                end
                mexp += len;
            end
            pos += len; rem -= len; k++;
            sec++;
            if (sec >= SPT) begin
                sec = 0; hd++;
                if (hd >= 2) begin hd = 0; cyl = (cyl + 1) % 512; end
            end
        end
        chk(sn == k, (errc >= 0) ? "R9" : "R2", "storage accesses", sn, k);
        chk((wr ? rd_cnt : wn) == mexp, (errc >= 0) ? "R9" : "R2", "memory bytes",
            wr ? rd_cnt : wn, mexp);
        chk((wr ? wn : rd_cnt) == 0, wr ? "R7" : "R8", "wrong direction bytes",
            wr ? wn : rd_cnt, 0);
    endtask

    task automatic try_ignored(input logic [2:0] code);
        bit seen = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; word_cnt = 16'hFFF0;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (busy || done || mem_req || sto_start) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R1", "ignored code activity", longint'(seen), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_req && !sto_start, "R10", "reset state",
            longint'({busy, done, mem_req, sto_start}), 0);
        try_ignored(3'd3);
        try_ignored(3'd0);
        try_ignored(3'd4);
        // R2: count of exactly 65536 bytes means nothing moves
        run_xfer(3'd6, 16'h0000, 16'h8000, 16'h0100, 2'd0, -1);
        // R6: start on last sector of head 1 so head and cylinder carry; R5 short tail
        run_xfer(3'd5, {9'd2, 1'b1, 6'(SPT - 1)}, 16'hFFEC, 16'h0400, 2'd1, -1);
        run_xfer(3'd6, {9'd2, 1'b1, 6'(SPT - 1)}, 16'hFFEC, 16'h1235, 2'd2, -1);
        run_xfer(3'd7, {9'd5, 1'b0, 6'd2}, 16'hFFF8, 16'h0800, 2'd0, -1);
        // R3: odd bus address and wrap of the 18-bit address
        run_xfer(3'd6, {9'd1, 1'b0, 6'd0}, 16'hFFF2, 16'hFFFB, 2'd3, -1);
        run_xfer(3'd5, {9'd0, 1'b1, 6'd1}, 16'hFFF0, 16'hFFF9, 2'd3, -1);
        // R9: storage errors
        run_xfer(3'd5, {9'd3, 1'b0, 6'd1}, 16'hFFE0, 16'h2000, 2'd0, 1);
        run_xfer(3'd6, {9'd3, 1'b0, 6'd1}, 16'hFFE0, 16'h2000, 2'd0, 0);
        run_xfer(3'd7, {9'd4, 1'b1, 6'd0}, 16'hFFD0, 16'h3000, 2'd1, 2);
        for (int n = 0; n < 24; n++) begin
            logic [2:0] code;
            code = 3'd5 + 3'(($urandom % 3));
            run_xfer(code,
                     {9'($urandom % CYLS), 1'($urandom), 6'($urandom % SPT)},
                     16'hFFFF - 16'($urandom % 64), 16'($urandom), 2'($urandom),
                     (($urandom % 5) == 0) ? int'($urandom % 4) : -1);
        end
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule